// File: doc/BRIEF.md
# Ten-Bit Timer Counter with Byte-Wide Register Access

This block is a 10-bit up/down timer counter that lives on an 8-bit register bus. Software reaches the full counter value through two byte locations. One is a low-byte window onto counter bits 7:0. The other is a two-bit staging register that carries bits 9:8. The staging register is also brought out of the block, so sibling wide registers in the same timer can share it.

Reading the low byte latches the matching upper bits into the staging register. Software should therefore read the low byte first and the staging register second. For writes the order is reversed: software writes the staging register first, then the low byte. The low-byte write loads all ten bits at once, after a short synchronisation delay. Any load turns the count direction to up. After that, the surrounding compare logic can pulse the block to reverse the direction.

The register port has no back-pressure. Each strobe completes in the cycle it is presented, and read data is valid in that same cycle. If software never touches the staging register, the counter works as a plain 8-bit timer with its upper bits held at zero.

Top module: `tcb10_timer`

## Requirements
- R1: After reset, the counter is 0, the staging register is 0 and the direction is up (`dir_down` low).
- R2: A write to address 1 stores `bus_wdata[1:0]` in the staging register. A read of address 1 returns the staging bits in bits 1:0, and bits 7:2 always read as zero.
- R3: A read of address 0 returns counter bits 7:0 in the same cycle. At that clock edge it also copies counter bits 9:8 into the staging register.
- R4: A write to address 0 loads the counter with `{staging[1:0], bus_wdata[7:0]}`. A write to address 1 never changes the counter.
- R5: With the default single synchronisation stage, a low-byte write sampled at edge k shows on the counter after edge k+1. A read between those two edges returns the old value.
- R6: While `cnt_en` is high and the direction is up, the counter adds one per clock and wraps from 0x3FF to 0.
- R7: While `cnt_en` is high and the direction is down, the counter subtracts one per clock and wraps from 0 to 0x3FF.
- R8: While `cnt_en` is low and no load is applied, the counter holds its value.
- R9: Applying a load sets the direction to up, whatever the direction was before.
- R10: A `turn_down` pulse sets the direction to down. A `turn_up` pulse sets it to up, and `turn_up` wins if both pulses arrive together.
- R11: When the staging register is zero, a low-byte write loads a value in 0..255, so the counter behaves as an 8-bit timer.
- R12: Addresses 2 and 3 read as zero. Writes to them change neither the counter nor the staging register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 staging, 2-3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| cnt_en | input | 1 | Count enable |
| turn_up | input | 1 | Pulse: count upward from now on |
| turn_down | input | 1 | Pulse: count downward from now on |
| count_value | output | 10 | Current counter value |
| dir_down | output | 1 | High while counting down |
| stage_bits | output | 2 | Staging register, shared with sibling wide registers |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, an 8-bit bus and one synchronisation stage. These values make the whole 1024-value space small enough to sweep. Every counter value is written through the two-byte sequence and read back. The bench then steps the counter through more than one full wrap in each direction, checking every single step. With one synchronisation stage, the exact load latency is a fixed two-edge window, and the bench probes it cycle by cycle.

// File: rtl/tcb10_pkg.sv
package tcb10_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/tcb10_stage.sv
module tcb10_stage #(
  parameter int HI_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hi,
  input  logic            cap_hi,
  input  logic [HI_W-1:0] wr_bits,
  input  logic [HI_W-1:0] cnt_hi,
  output logic [HI_W-1:0] stage_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      stage_q <= '0;
    else if (wr_hi)  stage_q <= wr_bits;
    else if (cap_hi) stage_q <= cnt_hi;
  end

  // R3: a low-byte read leaves the counter's upper bits in the staging register
  p_rdlo_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hi && !wr_hi) |=> stage_q == $past(cnt_hi));
  // R2: a staging write keeps the written bits
  p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> stage_q == $past(wr_bits));
  // R12: with no staging access the register holds
  p_stage_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !cap_hi) |=> $stable(stage_q));
endmodule

// File: rtl/tcb10_wrsync.sv
module tcb10_wrsync #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_value,
  output logic             load_valid,
  output logic [CNT_W-1:0] load_value
);
  logic [SYNC_STAGES-1:0] vld_q;
  logic [CNT_W-1:0]       val_q [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_pipe
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          val_q[g] <= '0;
        end else begin
          vld_q[g] <= wr_req;
          val_q[g] <= wr_value;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          val_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          val_q[g] <= val_q[g-1];
        end
      end
    end
  end

  assign load_valid = vld_q[SYNC_STAGES-1];
  assign load_value = val_q[SYNC_STAGES-1];
endmodule

// File: rtl/tcb10_core.sv
module tcb10_core
  import tcb10_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             cnt_en,
  input  logic             turn_up,
  input  logic             turn_down,
  output logic [CNT_W-1:0] cnt_q,
  output dir_e             dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      if (load_valid) begin
        cnt_q <= load_value;
        dir_q <= DIR_UP;
      end else begin
        if (cnt_en) begin
          if (dir_q == DIR_UP) cnt_q <= cnt_q + 1'b1;
          else                 cnt_q <= cnt_q - 1'b1;
        end
        if (turn_up)        dir_q <= DIR_UP;
        else if (turn_down) dir_q <= DIR_DOWN;
      end
    end
  end

  // R6: one step up per enabled cycle, modulo the counter width
  p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load_valid && dir_q == DIR_UP) |=> cnt_q == CNT_W'($past(cnt_q) + 1));
  // R7: one step down per enabled cycle, modulo the counter width
  p_down_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load_valid && dir_q == DIR_DOWN) |=> cnt_q == CNT_W'($past(cnt_q) - 1));
  // R8: no enable and no load means no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_valid) |=> $stable(cnt_q));
  // R9: a load lands the value and restores upward counting
  p_load_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (dir_q == DIR_UP && cnt_q == $past(load_value)));
  // R10: a down pulse without a load or an up pulse turns the direction
  p_turn_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_down && !turn_up && !load_valid) |=> dir_q == DIR_DOWN);
endmodule

// File: rtl/tcb10_timer.sv
module tcb10_timer
  import tcb10_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 2,
  parameter int ADDR_LO     = 0,
  parameter int ADDR_HI     = 1,
  parameter int SYNC_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               cnt_en,
  input  logic               turn_up,
  input  logic               turn_down,
  output logic [CNT_W-1:0]   count_value,
  output logic               dir_down,
  output logic [CNT_W-BUS_W-1:0] stage_bits
);
  localparam int HI_W = CNT_W - BUS_W;

  logic             sel_lo, sel_hi;
  logic             wr_lo, wr_hi, cap_hi;
  logic [HI_W-1:0]  stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_valid;
  logic [CNT_W-1:0] load_value;
  dir_e             dir_q;

  assign sel_lo = (bus_addr == ADDR_W'(ADDR_LO));
  assign sel_hi = (bus_addr == ADDR_W'(ADDR_HI));
  assign wr_lo  = bus_wr && sel_lo;
  assign wr_hi  = bus_wr && sel_hi;
  assign cap_hi = bus_rd && !bus_wr && sel_lo;

  tcb10_stage #(.HI_W(HI_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .cap_hi  (cap_hi),
    .wr_bits (bus_wdata[HI_W-1:0]),
    .cnt_hi  (cnt_q[CNT_W-1:BUS_W]),
    .stage_q (stage_q)
  );

  tcb10_wrsync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_lo),
    .wr_value   ({stage_q, bus_wdata}),
    .load_valid (load_valid),
    .load_value (load_value)
  );

  tcb10_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_value (load_value),
    .cnt_en     (cnt_en),
    .turn_up    (turn_up),
    .turn_down  (turn_down),
    .cnt_q      (cnt_q),
    .dir_q      (dir_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_lo)      bus_rdata = cnt_q[BUS_W-1:0];
    else if (sel_hi) bus_rdata = {{(BUS_W-HI_W){1'b0}}, stage_q};
  end

  assign count_value = cnt_q;
  assign dir_down    = (dir_q == DIR_DOWN);
  assign stage_bits  = stage_q;

  // R2: the reserved staging bits never read as one
  p_hi_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_hi) |-> bus_rdata[BUS_W-1:HI_W] == '0);
  // R12: unused addresses return zero
  p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_lo && !sel_hi) |-> bus_rdata == '0);
endmodule

// File: tb/tcb10_timer_test.sv
module tcb10_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0, turn_up = 1'b0, turn_down = 1'b0;
  logic [9:0] count_value;
  logic       dir_down;
  logic [1:0] stage_bits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcb10_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .turn_up(turn_up),
    .turn_down(turn_down), .count_value(count_value), .dir_down(dir_down),
    .stage_bits(stage_bits)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load10(input int v);
    bus_write(2'd1, 8'(v >> 8));
    bus_write(2'd0, 8'(v & 255));
    idle(1);
  endtask

  task automatic pulse_down();
    turn_down = 1'b1; @(negedge clk); turn_down = 1'b0;
  endtask

  task automatic pulse_up();
    turn_up = 1'b1; @(negedge clk); turn_up = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    int exp;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 count", int'(count_value), 0);
    check("R1 dir", int'(dir_down), 0);
    bus_read(2'd1, d); check("R1 stage", d, 0);
    bus_read(2'd0, d); check("R1 low", d, 0);

    // R11 staging zero: byte write gives an 8-bit value
    bus_write(2'd0, 8'h55); idle(1);
    check("R11 count", int'(count_value), 'h055);
    bus_read(2'd1, d); check("R11 hi", d, 0);

    // R2 reserved bits, R4 staging write leaves counter alone
    bus_write(2'd1, 8'hFF);
    check("R4 count after hi write", int'(count_value), 'h055);
    bus_read(2'd1, d); check("R2 hi reads masked", d, 3);
    check("R2 shared stage port", int'(stage_bits), 3);

    // R12 unused addresses
    bus_write(2'd2, 8'hAA); bus_write(2'd3, 8'h01); idle(2);
    bus_read(2'd2, d); check("R12 addr2", d, 0);
    bus_read(2'd3, d); check("R12 addr3", d, 0);
    check("R12 count", int'(count_value), 'h055);
    check("R12 stage", int'(stage_bits), 3);

    // R5 latency: staging=3, write low 0x21 -> 0x321
    bus_write(2'd0, 8'h21);
    bus_read(2'd0, d); check("R5 before apply", d, 'h55);
    bus_read(2'd0, d); check("R5 after apply", d, 'h21);
    check("R5 full value", int'(count_value), 'h321);
    // R3: the read before the load captured old bits 9:8 (0), the later read captured 3
    check("R3 capture", int'(stage_bits), 3);

    // R3 / R4 exhaustive sweep
    for (int v = 0; v < 1024; v++) begin
      load10(v);
      bus_read(2'd0, d); check("R4 sweep low", d, v & 255);
      bus_read(2'd1, d); check("R3 sweep hi", d, v >> 8);
    end

    // R6 up wrap, step by step
    load10('h3F0);
    exp = 'h3F0;
    cnt_en = 1'b1;
    for (int i = 0; i < 1040; i++) begin
      @(negedge clk);
      exp = (exp + 1) % 1024;
      check("R6 up step", int'(count_value), exp);
    end
    cnt_en = 1'b0;

    // R8 hold
    idle(5);
    check("R8 hold", int'(count_value), exp);

    // R10 down pulse, R7 down wrap
    load10('h00A);
    pulse_down();
    check("R10 dir down", int'(dir_down), 1);
    exp = 'h00A;
    cnt_en = 1'b1;
    for (int i = 0; i < 1040; i++) begin
      @(negedge clk);
      exp = (exp + 1023) % 1024;
      check("R7 down step", int'(count_value), exp);
    end
    cnt_en = 1'b0;

    // R10 up pulse, and priority when both arrive
    pulse_up();
    check("R10 dir up", int'(dir_down), 0);
    turn_up = 1'b1; turn_down = 1'b1; @(negedge clk);
    turn_up = 1'b0; turn_down = 1'b0;
    check("R10 up wins", int'(dir_down), 0);

    // R9 load forces up
    pulse_down();
    check("R9 pre dir", int'(dir_down), 1);
    load10('h210);
    check("R9 dir after load", int'(dir_down), 0);
    cnt_en = 1'b1; idle(3); cnt_en = 1'b0;
    check("R9 counts up", int'(count_value), 'h213);
    bus_read(2'd0, d); check("R9 low", d, 'h13);
    bus_read(2'd1, d); check("R3 hi", d, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule